// File: doc/BRIEF.md
# Double-Buffered Serial DAC Input Register

This block is the digital front end of a 16-bit serial-input digital-to-analog converter. A host shifts a data word in over a three-wire link: a shift clock, a data line and an active-low frame select. The block collects the bits in a shift register. When a frame closes after exactly sixteen bits, it moves the word into an input latch. An active-low load input then copies the latch into the DAC data register, whose value drives the converter.

The serial pins are asynchronous to the block's system clock. Each one passes through a two-flop synchronizer, and the block detects edges on the synchronized copies. A host that sends bytes can split one frame into two bursts of eight clocks, provided it keeps the frame select low between them. A host that keeps the load input low all the time gets an automatic update each time a frame closes. The shift register's top bit is presented on a serial output so the host can read back what it shifted in. An active-low clear input forces the DAC register to zero at once.

Top module: `sdac_front`

## Requirements
- R1: After reset, `dac_code` is 0 and `sdo` is 0.
- R2: A complete frame with `ldac_n` high leaves `dac_code` unchanged. A later low pulse on `ldac_n` sets `dac_code` to the received word.
- R3: Bits are taken from `din` on falling edges of `sclk`. The first bit taken is bit 15 of the word and the last is bit 0.
- R4: A frame sent as two bursts of eight falling `sclk` edges, with `sync_n` held low through the pause between them, delivers the same word as an unbroken frame.
- R5: While `ldac_n` is held low, `dac_code` takes the new word within a few system clocks after `sync_n` rises at the end of a complete frame.
- R6: A frame that closes after fewer or more than 16 falling `sclk` edges is discarded. A later `ldac_n` pulse restores the previously latched word to `dac_code`.
- R7: `sdo` presents bit 15 of the shift register. During a frame it shows the earlier contents one bit per falling `sclk` edge, highest bit first.
- R8: While `clr_n` is low, `dac_code` is 0. The clear acts without waiting for a clock edge and overrides a low `ldac_n`. After release, `dac_code` reloads only through `ldac_n`.
- R9: `sclk` edges while `sync_n` is high change neither the shift register (seen on `sdo`) nor the latched word.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sclk | input | 1 | Serial shift clock; data taken on its falling edge |
| din | input | 1 | Serial data, MSB first |
| sync_n | input | 1 | Active-low frame select |
| ldac_n | input | 1 | Active-low load of the latch into the DAC register |
| clr_n | input | 1 | Active-low asynchronous clear of the DAC register |
| sdo | output | 1 | Serial readback of the shift register's top bit |
| dac_code | output | WIDTH | DAC data register value |

## Verification
The bench sends single unbroken frames, split two-burst frames, short and overlong frames, and clock activity with the frame select high. Comparing the DAC code after each pattern separates a correct bit count and bit order from frames that should be dropped. It also checks that `sclk` is ignored outside a frame. The bench runs the same words once with a separate load pulse and once with the load input held low, which shows whether the double buffering holds a word back or passes it straight through. Clear pulses are applied under both load settings to check that the clear wins over the load and that the register does not reload by itself after release.

// File: rtl/sdac_front.sv
module sdac_front #(
  parameter int WIDTH = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sclk,
  input  logic             din,
  input  logic             sync_n,
  input  logic             ldac_n,
  input  logic             clr_n,
  output logic             sdo,
  output logic [WIDTH-1:0] dac_code
);
  localparam int CW = $clog2(WIDTH + 2);
  localparam logic [CW-1:0] FULL = CW'(WIDTH);
  localparam logic [CW-1:0] OVER = CW'(WIDTH + 1);
  localparam logic [3:0] IDLE = 4'b0011;

  // {sclk, din, sync_n, ldac_n}
  logic [3:0] meta_q, pins_q;
  logic       sclk_d, sync_d;
  logic [CW-1:0]    cnt;
  logic [WIDTH-1:0] shreg, latch;

  wire sclk_s = pins_q[3];
  wire din_s  = pins_q[2];
  wire sync_s = pins_q[1];
  wire ldac_s = pins_q[0];

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      meta_q <= IDLE;
      pins_q <= IDLE;
      sclk_d <= 1'b0;
      sync_d <= 1'b1;
    end else begin
      meta_q <= {sclk, din, sync_n, ldac_n};
      pins_q <= meta_q;
      sclk_d <= sclk_s;
      sync_d <= sync_s;
    end

  wire sclk_fall   = sclk_d & ~sclk_s;
  wire frame_start = sync_d & ~sync_s;
  wire frame_end   = ~sync_d & sync_s;
  wire shift_en    = sclk_fall & ~sync_s;
  wire word_ok     = frame_end & (cnt == FULL);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      cnt <= '0;
    else if (frame_start)
      cnt <= shift_en ? CW'(1) : '0;
    else if (shift_en && cnt != OVER)
      cnt <= cnt + CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      shreg <= '0;
    else if (shift_en)
      shreg <= {shreg[WIDTH-2:0], din_s};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n)
      latch <= '0;
    else if (word_ok)
      latch <= shreg;

  always_ff @(posedge clk or negedge rst_n or negedge clr_n)
    if (!rst_n || !clr_n)
      dac_code <= '0;
    else if (!ldac_s)
      dac_code <= latch;

  assign sdo = shreg[WIDTH-1];
endmodule

// File: rtl/sdac_front_chk.sv
module sdac_front_chk #(
  parameter int WIDTH = 16,
  parameter int CW    = 5
) (
  input logic             clk,
  input logic             rst_n,
  input logic             clr_n,
  input logic             ldac_s,
  input logic             sync_s,
  input logic [CW-1:0]    cnt,
  input logic [WIDTH-1:0] shreg,
  input logic [WIDTH-1:0] latch,
  input logic [WIDTH-1:0] dac_code
);
  AST_CLEAR_FORCES_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    !clr_n |-> dac_code == '0); // R8

  AST_DAC_MOVES_ON_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
    (!$stable(dac_code) && clr_n && $past(clr_n)) |-> !$past(ldac_s)); // R2

  AST_LATCH_NEEDS_FULL_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(latch) |-> $past(cnt) == CW'(WIDTH)); // R6

  AST_SHIFT_ONLY_IN_FRAME: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(shreg) |-> !$past(sync_s)); // R9
endmodule

bind sdac_front sdac_front_chk #(.WIDTH(WIDTH), .CW(CW)) u_chk (
  .clk(clk), .rst_n(rst_n), .clr_n(clr_n), .ldac_s(ldac_s), .sync_s(sync_s),
  .cnt(cnt), .shreg(shreg), .latch(latch), .dac_code(dac_code)
);

// File: tb/sdac_front_test.sv
module sdac_front_test;
  localparam int W = 16;

  logic clk = 0, rst_n = 0, sclk = 0, din = 0, sync_n = 1, ldac_n = 1, clr_n = 1;
  wire sdo;
  wire [W-1:0] dac_code;

  sdac_front #(.WIDTH(W)) uut (
    .clk(clk), .rst_n(rst_n), .sclk(sclk), .din(din), .sync_n(sync_n),
    .ldac_n(ldac_n), .clr_n(clr_n), .sdo(sdo), .dac_code(dac_code)
  );

  always #5 clk = ~clk;

  int checks = 0, errors = 0;

  typedef struct { logic [W-1:0] val; string tag; } exp_t;
  exp_t exp_q[$];
  event exp_ev;

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_dac(input logic [W-1:0] v, input string tag);
    exp_t e;
    e.val = v;
    e.tag = tag;
    exp_q.push_back(e);
    -> exp_ev;
    #1;
  endtask

  initial forever begin
    @(exp_ev);
    while (exp_q.size() > 0) begin
      exp_t e;
      e = exp_q.pop_front();
      checks++;
      if (dac_code !== e.val) begin
        errors++;
        $display("FAIL %s: dac_code=%h expected %h", e.tag, dac_code, e.val);
      end
    end
  end

  task automatic check_sdo(input logic v, input string tag);
    checks++;
    if (sdo !== v) begin
      errors++;
      $display("FAIL %s: sdo=%b expected %b", tag, sdo, v);
    end
  endtask

  task automatic send(input logic [31:0] w, input int n, input bit split,
                      input bit chk, input logic [W-1:0] prev);
    sync_n = 0;
    tick(6);
    for (int i = 0; i < n; i++) begin
      sclk = 1;
      din = w[n-1-i];
      tick(6);
      if (chk) check_sdo(prev[W-1-i], "R7");
      sclk = 0;
      tick(6);
      if (split && i == 7) tick(24);
    end
    tick(6);
    sync_n = 1;
    tick(8);
  endtask

  task automatic load_pulse();
    ldac_n = 0;
    tick(6);
    ldac_n = 1;
    tick(6);
  endtask

  initial begin
    tick(3);
    rst_n = 1;
    tick(3);
    expect_dac(16'h0000, "R1");
    check_sdo(1'b0, "R1");

    // R2 / R3: full frame held back until load
    send(32'hA5C3, 16, 0, 0, '0);
    expect_dac(16'h0000, "R2");
    load_pulse();
    expect_dac(16'hA5C3, "R3");

    // R4: two bursts of eight
    send(32'h1234, 16, 1, 0, '0);
    expect_dac(16'hA5C3, "R4");
    load_pulse();
    expect_dac(16'h1234, "R4");

    // R6: short and long frames dropped
    send(32'h03FF, 10, 0, 0, '0);
    load_pulse();
    expect_dac(16'h1234, "R6");
    send(32'h000F_FFFF, 20, 0, 0, '0);
    load_pulse();
    expect_dac(16'h1234, "R6");

    // R7: readback of previous shift contents
    send(32'h8001, 16, 0, 0, '0);
    send(32'h6B2D, 16, 0, 1, 16'h8001);
    load_pulse();
    expect_dac(16'h6B2D, "R3");

    // R9: clock activity outside a frame
    din = 1;
    for (int i = 0; i < 16; i++) begin
      sclk = 1; tick(6);
      sclk = 0; tick(6);
    end
    check_sdo(1'b0, "R9");
    load_pulse();
    expect_dac(16'h6B2D, "R9");

    // R5: load held low gives automatic update
    ldac_n = 0;
    tick(6);
    send(32'h4E71, 16, 0, 0, '0);
    expect_dac(16'h4E71, "R5");

    // R8: clear with load low, then with load high
    clr_n = 0;
    #1;
    expect_dac(16'h0000, "R8");
    tick(4);
    expect_dac(16'h0000, "R8");
    clr_n = 1;
    tick(6);
    expect_dac(16'h4E71, "R8");
    ldac_n = 1;
    tick(6);
    clr_n = 0;
    tick(4);
    clr_n = 1;
    tick(8);
    expect_dac(16'h0000, "R8");
    load_pulse();
    expect_dac(16'h4E71, "R8");

    tick(4);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: run did not complete, expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule